// File: doc/BRIEF.md
# Masked Beam-Position Condition Comparator

This block decides whether a beam-synchronised wait or skip condition is satisfied. It takes the two 16-bit words of a wait/skip instruction, the live vertical and horizontal beam counters, and a flag that reports that the blitter has finished. From these it produces one registered `cond_met` bit that the instruction sequencer samples.

The first word carries the target beam position. The second word carries a per-bit enable for each position bit, together with a bit that switches off the blitter qualifier. Bits that are not enabled are cleared in both the beam position and the target position. The two cleared values are then compared as unsigned numbers. The vertical field forms the upper part of each value and the horizontal field the lower part.

The result is captured only on cycles where `cyc_en` marks a memory-cycle boundary, and it holds between those cycles. Generating the beam counters and sequencing instructions are handled outside this block.

Top module: `beam_cond_cmp`

## Requirements
- R1: In `word1`, bits 15..8 are the vertical target V7..V0 and bits 7..1 are the horizontal target H8..H2. Bit 0 has no effect.
- R2: In `word2`, bits 14..8 enable vertical bits V6..V0 and bits 7..1 enable horizontal bits H8..H2. A 1 means the bit takes part in the comparison. Bit 0 has no effect.
- R3: Vertical bit 7 always takes part in the comparison, whatever the enables are. With every enable at 0 and `word2[15]`=1, the result is `vpos[7] >= word1[15]`.
- R4: The beam value is `{vpos[7:0], hpos[8:2]}` and the target value is `{word1[15:8], word1[7:1]}`. Both are 15-bit values, and disabled bits are cleared in both. The condition holds when the cleared beam value is greater than or equal to the cleared target value, compared as unsigned numbers.
- R5: A beam value exactly equal to the target value satisfies the condition.
- R6: When `word2[15]`=1, `blit_done` has no effect on the result.
- R7: When `word2[15]`=0, the result is 1 only if `blit_done`=1 and the position test of R4 also passes.
- R8: `hpos[1:0]` has no effect on the result.
- R9: `cond_met` takes the evaluated result at the rising clock edge where `cyc_en`=1, so it has one cycle of latency. On edges where `cyc_en`=0 it keeps its previous value.
- R10: While `rst_n`=0, `cond_met` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Memory-cycle enable; capture result when 1 |
| word1 | input | 16 | Target-position instruction word |
| word2 | input | 16 | Enable/qualifier instruction word |
| vpos | input | 8 | Vertical beam counter |
| hpos | input | 9 | Horizontal beam counter |
| blit_done | input | 1 | Blitter finished flag |
| cond_met | output | 1 | Registered condition result |

## Verification
The hardest outcomes to reach from the ports are the ones where masking flips the result. In these cases, a beam position that is smaller than the target when all bits are compared becomes greater than or equal once some bits are cleared, or the other way round. A separate hard case is the unmaskable vertical top bit deciding the result by itself. The stimulus reaches both by fixing several enable patterns and then sweeping every vertical count against a spread of horizontal counts, with `blit_done` and the qualifier bit alternating. A directed pass forces the beam to equal the target exactly, and pseudo-random vectors cover arbitrary combinations.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  // Instruction word width and field geometry
  localparam int WORD_W  = 16;
  localparam int VPOS_W  = 8;
  localparam int HPOS_W  = 9;
  localparam int HDROP   = 2;
  localparam int HCMP_W  = HPOS_W - HDROP;
  localparam int POS_W   = VPOS_W + HCMP_W;
  localparam int H_LSB   = 1;
  localparam int V_LSB   = H_LSB + HCMP_W;
  localparam int QUAL_BIT = WORD_W - 1;

  typedef logic [POS_W-1:0] pos_t;

  typedef struct packed {
    pos_t target;
    pos_t enable;
    logic blit_ignore;
  } cond_fields_t;
endpackage

// File: rtl/bcc_fields.sv
module bcc_fields
  import bcc_pkg::*;
#(
  parameter int WW = WORD_W,
  parameter int VW = VPOS_W,
  parameter int HW = HCMP_W
) (
  input  logic [WW-1:0] w_pos,
  input  logic [WW-1:0] w_en,
  output cond_fields_t  fields
);
  localparam int PW = VW + HW;
  localparam int VL = H_LSB + HW;

  pos_t en_bits;

  // Horizontal enables come straight from the enable word
  for (genvar i = 0; i < HW; i++) begin : g_hen
    assign en_bits[i] = w_en[H_LSB + i];
  end

  // Vertical enables: the top vertical bit has no enable and is always on
  for (genvar j = 0; j < VW; j++) begin : g_ven
    if (j == VW - 1) begin : g_top
      assign en_bits[HW + j] = 1'b1;
    end else begin : g_mask
      assign en_bits[HW + j] = w_en[VL + j];
    end
  end

  always_comb begin
    fields.target      = {w_pos[VL +: VW], w_pos[H_LSB +: HW]};
    fields.enable      = en_bits;
    fields.blit_ignore = w_en[WW-1];
  end

  logic unused_bits;
  assign unused_bits = w_pos[0] ^ w_en[0];
endmodule

// File: rtl/bcc_ge.sv
module bcc_ge
  import bcc_pkg::*;
(
  input  pos_t beam,
  input  pos_t target,
  input  pos_t enable,
  output logic ge
);
  pos_t beam_m;
  pos_t targ_m;

  always_comb begin
    beam_m = beam & enable;
    targ_m = target & enable;
    ge     = (beam_m >= targ_m);
  end
endmodule

// File: rtl/beam_cond_cmp.sv
module beam_cond_cmp
  import bcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic [WORD_W-1:0] word1,
  input  logic [WORD_W-1:0] word2,
  input  logic [VPOS_W-1:0] vpos,
  input  logic [HPOS_W-1:0] hpos,
  input  logic              blit_done,
  output logic              cond_met
);
  cond_fields_t fld;
  pos_t         beam;
  logic         pos_ok;
  logic         eval;
  logic         met_q;
  logic         met_nxt;

  bcc_fields u_fields (
    .w_pos  (word1),
    .w_en   (word2),
    .fields (fld)
  );

  assign beam = {vpos, hpos[HPOS_W-1:HDROP]};

  bcc_ge u_ge (
    .beam   (beam),
    .target (fld.target),
    .enable (fld.enable),
    .ge     (pos_ok)
  );

  // Next-state: qualifier gate and clock enable
  always_comb begin
    eval    = pos_ok & (fld.blit_ignore | blit_done);
    met_nxt = cyc_en ? eval : met_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) met_q <= 1'b0;
    else        met_q <= met_nxt;
  end

  assign cond_met = met_q;

  logic unused_h;
  assign unused_h = ^hpos[HDROP-1:0];
endmodule

// File: rtl/bcc_chk.sv
module bcc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cyc_en,
  input logic [15:0] word1,
  input logic [15:0] word2,
  input logic [7:0]  vpos,
  input logic [8:0]  hpos,
  input logic        blit_done,
  input logic        cond_met
);
  // R10
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> !cond_met);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> $stable(cond_met));

  // R7
  blit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en && !word2[15] && !blit_done |=> !cond_met);

  // R3
  top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en && ((word2 & 16'hFFFE) == 16'h8000)
    |=> cond_met == ($past(vpos[7]) | ~$past(word1[15])));

  // R5
  equal_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en && word2[15] && ({vpos, hpos[8:2]} == word1[15:1]) |=> cond_met);
endmodule

bind beam_cond_cmp bcc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_en    (cyc_en),
  .word1     (word1),
  .word2     (word2),
  .vpos      (vpos),
  .hpos      (hpos),
  .blit_done (blit_done),
  .cond_met  (cond_met)
);

// File: tb/sim_beam_cond_cmp.sv
`timescale 1ns/1ps
module sim_beam_cond_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_en = 1'b0;
  logic [15:0] word1 = '0;
  logic [15:0] word2 = '0;
  logic [7:0]  vpos = '0;
  logic [8:0]  hpos = '0;
  logic        blit_done = 1'b0;
  logic        cond_met;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #10 clk = ~clk;

  beam_cond_cmp u0 (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .word1(word1), .word2(word2),
    .vpos(vpos), .hpos(hpos), .blit_done(blit_done), .cond_met(cond_met)
  );

  function automatic logic [31:0] nxt(logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // Reference from R1..R8: arithmetic on 15-bit values
  function automatic logic model(logic [15:0] a, logic [15:0] b,
                                 logic [7:0] v, logic [8:0] h, logic bd);
    int mv, mh, bv, tv;
    mv = 128 + int'(b[14:8]);
    mh = int'(b[7:1]);
    bv = (int'(v) & mv) * 128 + ((int'(h) / 4) & mh);
    tv = (int'(a[15:8]) & mv) * 128 + (int'(a[7:1]) & mh);
    return (bv >= tv) && (b[15] || bd);
  endfunction

  task automatic check(logic exp, string req);
    n_vec++;
    if (cond_met !== exp) begin
      n_bad++;
      $display("FAIL %s: w1=%h w2=%h v=%h h=%h bd=%b got %b exp %b",
               req, word1, word2, vpos, hpos, blit_done, cond_met, exp);
    end
  endtask

  // Called at a negedge: drive, let one capture edge pass, check at next negedge
  task automatic apply(logic [15:0] a, logic [15:0] b, logic [7:0] v,
                       logic [8:0] h, logic bd, string req);
    word1 = a; word2 = b; vpos = v; hpos = h; blit_done = bd; cyc_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(model(a, b, v, h, bd), req);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] masks [4];
    logic [15:0] targs [2];
    logic        hold_val;
    masks[0] = 16'hFFFE; masks[1] = 16'h8000; masks[2] = 16'h80FE; masks[3] = 16'h7F00;
    targs[0] = 16'h6A52; targs[1] = 16'hC3A9;

    // R10: reset state
    repeat (3) @(negedge clk);
    check(1'b0, "R10");
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R6 R7: sweep every vertical count under fixed enable patterns
    for (int m = 0; m < 4; m++)
      for (int t = 0; t < 2; t++)
        for (int v = 0; v < 256; v++)
          for (int hi = 0; hi < 8; hi++)
            apply(targs[t], masks[m] ^ ((hi & 1) ? 16'h8000 : 16'h0000),
                  8'(v), 9'(hi * 67 + v), hi[1], "R4");

    // R5: beam exactly at target, qualifier off
    for (int k = 0; k < 64; k++) begin
      rng = nxt(rng);
      apply(rng[15:0] & 16'hFFFE, rng[31:16] | 16'h8000, rng[15:8],
            {rng[7:1], 2'b00}, 1'b0, "R5");
      check(1'b1, "R5");
    end

    // R3: enables all off, only the top vertical bit decides
    for (int k = 0; k < 256; k++) begin
      rng = nxt(rng);
      apply(rng[15:0], 16'h8000, rng[23:16], rng[31:23], rng[5], "R3");
    end

    // R8: low horizontal bits and word bit 0 have no effect
    for (int k = 0; k < 128; k++) begin
      rng = nxt(rng);
      for (int lo = 0; lo < 4; lo++)
        apply(rng[15:0] ^ 16'(lo & 1), rng[31:16] ^ 16'(lo >> 1), rng[7:0],
              {rng[20:14], 2'(lo)}, rng[9], "R8");
    end

    // R6 R7: random vectors, both qualifier settings
    for (int k = 0; k < 4000; k++) begin
      rng = nxt(rng);
      word1 = rng[15:0];
      rng = nxt(rng);
      apply(word1, rng[15:0], rng[23:16], rng[31:23], rng[16],
            rng[15] ? "R6" : "R7");
    end

    // R9: with cyc_en low the output holds while inputs change
    for (int k = 0; k < 200; k++) begin
      rng = nxt(rng);
      apply(16'h0000, 16'h8000, 8'h00, 9'h000, 1'b0, "R9");
      hold_val = cond_met;
      cyc_en = 1'b0;
      word1 = 16'hFFFE; word2 = {1'b0, rng[14:0]}; vpos = 8'h00; blit_done = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check(hold_val, "R9");
      word1 = rng[15:0] | 16'h8000; word2 = 16'hFFFE; vpos = rng[23:16] & 8'h7F;
      cyc_en = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check(1'b1, "R9");
    end

    // R10: reset mid-run clears a set output
    apply(16'h0000, 16'h8000, 8'h10, 9'h000, 1'b0, "R10");
    rst_n = 1'b0;
    #1;
    check(1'b0, "R10");
    @(negedge clk);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule